// File: doc/BRIEF.md
# I2C Configuration Register File

This block is the control plane of a serial-link endpoint. It is an I2C target that runs on the system clock and oversamples SCL and SDA. Behind it sits a small map of 8-bit registers. These registers drive the endpoint's pixel-edge select, clock and I/O-voltage modes, equaliser gain, spread-spectrum code and eight general-purpose pins. The map also exposes two live status inputs.

The 7-bit bus address comes from a strapped input vector, or from a programmable address register once its override bit is set. A write transaction sets the internal register pointer with its first data byte. Every later byte, whether written or read, moves the pointer up by one.

The reset register has two self-clearing bits. One bit restores the configuration registers while the bus engine and the address register keep running. The other bit only issues a one-cycle reset pulse to the datapath.

Top module: `cfg_i2c_regfile`

## Requirements
- R1: A START (SDA falling while SCL is high) begins address reception from any state. A STOP (SDA rising while SCL is high) returns the target to idle with SDA released.
- R2: The target pulls SDA low during the acknowledge clock of an address byte whose upper 7 bits equal the active address, and of every data byte written to it. For any other address it never drives SDA, and the register outputs remain unchanged.
- R3: Register 0x00 holds the programmable address in bits 7:1 (default ADDR_DEF) and the override in bit 0 (default 0). When bit 0 is 0 the active address is strap_addr; when it is 1 the active address is bits 7:1.
- R4: After a write address, the first data byte loads the pointer. Each further byte is written to the register at the pointer, and the pointer then advances by one, wrapping from 0xFF to 0x00.
- R5: A read transaction returns the register at the pointer, MSB first, and advances the pointer after each byte. A master NACK ends the read, and SDA is released before the STOP.
- R6: Writing register 0x01 with bit 1 set restores registers 0x02 to 0x05 to their defaults. Register 0x00 is unchanged, and the transaction continues: the next byte goes to 0x02.
- R7: Writing register 0x01 with bit 0 set gives exactly one clock cycle of core_rst high and leaves every register unchanged. Register 0x01 always reads 0x00.
- R8: Register 0x03 holds edge_rise in bit 0 (default 1, rising edge), vio_hi in bit 4 (default 0) and vio_auto in bit 5 (default 1). Its other bits read 0.
- R9: Register 0x02 holds spread_sel in bits 3:0 (default 0000, meaning spreading off) and clk_auto in bit 5 (default 0). Register 0x04 holds eq_gain (default 0x00). Unlisted bits read 0.
- R10: Register 0x05 drives gp_out bit for bit, where 1 means high. It resets to 0x00.
- R11: Register 0x06 is read-only, with sig_detect in bit 1, pll_locked in bit 0 and 0 in the other bits. Writes to it are ignored.
- R12: Registers 0x07 to 0xFF read as RSVD_FILL, and writes to them are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 20x the SCL rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl | input | 1 | I2C clock line |
| sda_in | input | 1 | I2C data line as seen on the pad |
| sda_oe | output | 1 | High pulls SDA low (open drain) |
| strap_addr | input | 7 | Strapped bus address |
| sig_detect | input | 1 | Status: incoming signal present |
| pll_locked | input | 1 | Status: CDR/PLL locked |
| edge_rise | output | 1 | Pixel-clock edge select, 1 = rising |
| clk_auto | output | 1 | Clock auto-switch enable |
| vio_auto | output | 1 | I/O-voltage auto detect enable |
| vio_hi | output | 1 | Manual I/O-voltage select, 1 = high rail |
| spread_sel | output | 4 | Spread-spectrum code |
| eq_gain | output | 8 | Equaliser gain code |
| gp_out | output | 8 | General-purpose outputs |
| core_rst | output | 1 | One-cycle datapath reset pulse |

## Verification
Writes are sent as multi-byte bursts that cross both writable registers and reserved or read-only slots. This separates true stores from ignored writes and shows that the pointer advances. Reads use a repeated START and an acknowledged run ended by a NACK, which shows whether the target keeps streaming or lets go of SDA. The address is exercised with the strap, with a foreign address and with the programmed override. Both reset bits are written in bursts that continue past register 0x01, which tells a full restore apart from a pulse-only reset and shows that the transaction survives it.

// File: rtl/cfg_i2c_regfile.sv
module cfg_i2c_regfile #(
  parameter logic [6:0] ADDR_DEF  = 7'h3A,
  parameter logic [7:0] RSVD_FILL = 8'h5A
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl,
  input  logic       sda_in,
  output logic       sda_oe,
  input  logic [6:0] strap_addr,
  input  logic       sig_detect,
  input  logic       pll_locked,
  output logic       edge_rise,
  output logic       clk_auto,
  output logic       vio_auto,
  output logic       vio_hi,
  output logic [3:0] spread_sel,
  output logic [7:0] eq_gain,
  output logic [7:0] gp_out,
  output logic       core_rst
);

  typedef enum logic [2:0] {S_IDLE, S_ADDR, S_ACK, S_WR, S_RD, S_MACK} st_t;

  logic [1:0] scl_q, sda_q;
  logic       scl_d, sda_d;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      scl_q <= 2'b11; sda_q <= 2'b11; scl_d <= 1'b1; sda_d <= 1'b1;
    end else begin
      scl_q <= {scl_q[0], scl};
      sda_q <= {sda_q[0], sda_in};
      scl_d <= scl_q[1];
      sda_d <= sda_q[1];
    end

  wire scl_s  = scl_q[1];
  wire sda_s  = sda_q[1];
  wire start_c = scl_s & scl_d & sda_d & ~sda_s;
  wire stop_c  = scl_s & scl_d & ~sda_d & sda_s;
  wire rise   = scl_s & ~scl_d;
  wire fall   = ~scl_s & scl_d;

  st_t        st;
  logic [2:0] cnt;
  logic [7:0] sh, ptr, rdata;
  logic       rw, first, ack_on, nack;
  logic [6:0] addr_r;
  logic       ovr_r;

  wire [7:0] byte_in = {sh[6:0], sda_s};
  wire [6:0] my_addr = ovr_r ? addr_r : strap_addr;
  wire       wr_en   = (st == S_WR) && rise && (cnt == 3'd7) && !first;
  wire       cfg_rst = wr_en && (ptr == 8'h01) && byte_in[1];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      addr_r <= ADDR_DEF; ovr_r <= 1'b0;
      clk_auto <= 1'b0; spread_sel <= 4'h0;
      vio_auto <= 1'b1; vio_hi <= 1'b0; edge_rise <= 1'b1;
      eq_gain <= 8'h00; gp_out <= 8'h00; core_rst <= 1'b0;
    end else begin
      core_rst <= wr_en && (ptr == 8'h01) && byte_in[0];
      if (cfg_rst) begin
        clk_auto <= 1'b0; spread_sel <= 4'h0;
        vio_auto <= 1'b1; vio_hi <= 1'b0; edge_rise <= 1'b1;
        eq_gain <= 8'h00; gp_out <= 8'h00;
      end else if (wr_en) begin
        case (ptr)
          8'h00: {addr_r, ovr_r} <= byte_in;
          8'h02: begin clk_auto <= byte_in[5]; spread_sel <= byte_in[3:0]; end
          8'h03: begin vio_auto <= byte_in[5]; vio_hi <= byte_in[4]; edge_rise <= byte_in[0]; end
          8'h04: eq_gain <= byte_in;
          8'h05: gp_out <= byte_in;
          default: ;
        endcase
      end
    end

  always_comb
    case (ptr)
      8'h00:   rdata = {addr_r, ovr_r};
      8'h01:   rdata = 8'h00;
      8'h02:   rdata = {2'b00, clk_auto, 1'b0, spread_sel};
      8'h03:   rdata = {2'b00, vio_auto, vio_hi, 3'b000, edge_rise};
      8'h04:   rdata = eq_gain;
      8'h05:   rdata = gp_out;
      8'h06:   rdata = {6'b0, sig_detect, pll_locked};
      default: rdata = RSVD_FILL;
    endcase

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st <= S_IDLE; cnt <= 3'd0; sh <= 8'h00; ptr <= 8'h00;
      rw <= 1'b0; first <= 1'b0; ack_on <= 1'b0; nack <= 1'b0;
    end else if (start_c) begin
      st <= S_ADDR; cnt <= 3'd0; ack_on <= 1'b0;
    end else if (stop_c) begin
      st <= S_IDLE; ack_on <= 1'b0;
    end else begin
      case (st)
        S_ADDR: if (rise) begin
          sh <= byte_in; cnt <= cnt + 3'd1;
          if (cnt == 3'd7) begin
            if (byte_in[7:1] == my_addr) begin
              st <= S_ACK; rw <= byte_in[0]; first <= 1'b1;
            end else st <= S_IDLE;
          end
        end
        S_ACK: if (fall) begin
          if (!ack_on) ack_on <= 1'b1;
          else begin
            ack_on <= 1'b0; cnt <= 3'd0;
            if (rw) begin st <= S_RD; sh <= rdata; end
            else st <= S_WR;
          end
        end
        S_WR: if (rise) begin
          sh <= byte_in; cnt <= cnt + 3'd1;
          if (cnt == 3'd7) begin
            st <= S_ACK;
            if (first) begin ptr <= byte_in; first <= 1'b0; end
            else ptr <= ptr + 8'd1;
          end
        end
        S_RD: if (fall) begin
          sh <= {sh[6:0], 1'b0}; cnt <= cnt + 3'd1;
          if (cnt == 3'd7) begin st <= S_MACK; ptr <= ptr + 8'd1; end
        end
        S_MACK: begin
          if (rise) nack <= sda_s;
          if (fall) begin
            if (nack) st <= S_IDLE;
            else begin st <= S_RD; sh <= rdata; cnt <= 3'd0; end
          end
        end
        default: st <= S_IDLE;
      endcase
    end

  assign sda_oe = ack_on | ((st == S_RD) & ~sh[7]);

  // R1
  stop_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_c |=> !sda_oe);
  // R2
  drive_low_scl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !scl_s);
  // R5
  nack_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_MACK && fall && nack) |=> !sda_oe);
  // R6
  addr_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_rst |=> $stable({addr_r, ovr_r}));
  // R6
  cfg_dflt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_rst |=> (edge_rise && vio_auto && !vio_hi && gp_out == 8'h00 && eq_gain == 8'h00 && spread_sel == 4'h0));
  // R7
  core_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    core_rst |=> !core_rst);

endmodule

// File: tb/cfg_i2c_regfile_test.sv
module cfg_i2c_regfile_test;
  localparam int CLK_PERIOD = 10;
  localparam int T = 5;
  localparam logic [6:0] ADDR_DEF = 7'h3A;
  localparam logic [7:0] RSVD = 8'h5A;
  localparam logic [6:0] STRAP = 7'h21;

  logic clk = 1'b0, rst_n = 1'b0, scl = 1'b1, sda_m = 1'b1;
  logic sig_detect = 1'b1, pll_locked = 1'b0;
  logic sda_oe, edge_rise, clk_auto, vio_auto, vio_hi, core_rst;
  logic [3:0] spread_sel;
  logic [7:0] eq_gain, gp_out;
  wire sda_line = sda_m & ~sda_oe;

  always #(CLK_PERIOD/2) clk = ~clk;

  cfg_i2c_regfile #(.ADDR_DEF(ADDR_DEF), .RSVD_FILL(RSVD)) uut (
    .clk(clk), .rst_n(rst_n), .scl(scl), .sda_in(sda_line), .sda_oe(sda_oe),
    .strap_addr(STRAP), .sig_detect(sig_detect), .pll_locked(pll_locked),
    .edge_rise(edge_rise), .clk_auto(clk_auto), .vio_auto(vio_auto), .vio_hi(vio_hi),
    .spread_sel(spread_sel), .eq_gain(eq_gain), .gp_out(gp_out), .core_rst(core_rst));

  int checks = 0, errors = 0, pulses = 0, exp_pulses = 0;
  bit cmp_en = 1'b0, done = 1'b0;
  logic [7:0] m0, m2, m3, m4, m5, mptr;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] mread(input logic [7:0] p);
    case (p)
      8'h00: return m0;
      8'h01: return 8'h00;
      8'h02: return m2;
      8'h03: return m3;
      8'h04: return m4;
      8'h05: return m5;
      8'h06: return {6'b0, sig_detect, pll_locked};
      default: return RSVD;
    endcase
  endfunction

  task automatic mdefaults();
    m2 = 8'h00; m3 = 8'h21; m4 = 8'h00; m5 = 8'h00;
  endtask

  task automatic mwrite(input logic [7:0] p, input logic [7:0] v);
    case (p)
      8'h00: m0 = v;
      8'h01: begin if (v[1]) mdefaults(); if (v[0]) exp_pulses++; end
      8'h02: m2 = v & 8'h2F;
      8'h03: m3 = v & 8'h31;
      8'h04: m4 = v;
      8'h05: m5 = v;
      default: ;
    endcase
  endtask

  always @(negedge clk) if (core_rst) pulses++;

  always @(negedge clk) if (cmp_en) begin
    chk(edge_rise == m3[0], "R8 edge_rise", edge_rise, m3[0]);
    chk(vio_auto == m3[5] && vio_hi == m3[4], "R8 vio", {vio_auto, vio_hi}, {m3[5], m3[4]});
    chk(spread_sel == m2[3:0] && clk_auto == m2[5], "R9 clock ctl", {clk_auto, spread_sel}, {m2[5], m2[3:0]});
    chk(eq_gain == m4, "R9 eq_gain", eq_gain, m4);
    chk(gp_out == m5, "R10 gp_out", gp_out, m5);
    chk(!sda_oe && !core_rst, "R1 idle lines", {sda_oe, core_rst}, 0);
  end

  task automatic tick(input int n); repeat (n) @(negedge clk); endtask

  task automatic i2c_start();
    cmp_en = 1'b0;
    sda_m = 1'b1; tick(T); scl = 1'b1; tick(T); sda_m = 1'b0; tick(T); scl = 1'b0; tick(T);
  endtask

  task automatic i2c_stop();
    sda_m = 1'b0; tick(T); scl = 1'b1; tick(T); sda_m = 1'b1; tick(T + 6);
    cmp_en = 1'b1;
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; tick(T); scl = 1'b1; tick(2 * T); scl = 1'b0; tick(T);
    end
    sda_m = 1'b1; tick(T); scl = 1'b1; tick(T); ack = sda_line; tick(T); scl = 1'b0; tick(T);
  endtask

  task automatic recv_byte(input logic nk, output logic [7:0] b);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      tick(T); scl = 1'b1; tick(T); b[i] = sda_line; tick(T); scl = 1'b0;
    end
    sda_m = nk; tick(T); scl = 1'b1; tick(2 * T); scl = 1'b0; tick(T); sda_m = 1'b1;
  endtask

  task automatic wr(input logic [6:0] a, input logic [7:0] p, input logic [7:0] d[$]);
    logic ack;
    i2c_start();
    send_byte({a, 1'b0}, ack); chk(ack == 1'b0, "R2 addr ack", ack, 0);
    send_byte(p, ack); chk(ack == 1'b0, "R4 pointer ack", ack, 0);
    mptr = p;
    foreach (d[i]) begin
      send_byte(d[i], ack); chk(ack == 1'b0, "R2 data ack", ack, 0);
      mwrite(mptr, d[i]); mptr = mptr + 8'd1;
    end
    i2c_stop();
  endtask

  task automatic rd(input logic [6:0] a, input logic [7:0] p, input int n, input string req);
    logic ack;
    logic [7:0] b;
    i2c_start();
    send_byte({a, 1'b0}, ack); chk(ack == 1'b0, "R2 addr ack", ack, 0);
    send_byte(p, ack); mptr = p;
    i2c_start();
    send_byte({a, 1'b1}, ack); chk(ack == 1'b0, "R5 read addr ack", ack, 0);
    for (int i = 0; i < n; i++) begin
      recv_byte(i == n - 1, b);
      chk(b == mread(mptr), req, b, mread(mptr));
      mptr = mptr + 8'd1;
    end
    tick(2);
    chk(sda_oe == 1'b0, "R5 released after NACK", sda_oe, 0);
    i2c_stop();
  endtask

  task automatic probe_nack(input logic [6:0] a, input string req);
    logic ack;
    i2c_start();
    send_byte({a, 1'b0}, ack); chk(ack == 1'b1, req, ack, 1);
    i2c_stop();
  endtask

  initial begin
    m0 = {ADDR_DEF, 1'b0}; mdefaults(); mptr = 8'h00;
    tick(4); rst_n = 1'b1; tick(2);
    chk(edge_rise == 1'b1 && vio_auto == 1'b1 && gp_out == 8'h00, "R8 reset state",
        {edge_rise, vio_auto, gp_out}, {1'b1, 1'b1, 8'h00});
    chk(sda_oe == 1'b0 && core_rst == 1'b0, "R1 reset lines", {sda_oe, core_rst}, 0);
    cmp_en = 1'b1;

    // R4 R10 R11 R12: burst across gp register, status and reserved slot
    wr(STRAP, 8'h05, '{8'hA5, 8'h3C, 8'h77});
    // R2: foreign address gets no acknowledge, outputs untouched
    probe_nack(7'h50, "R2 foreign addr nack");
    // R5 R9 R11: streamed read 0x02..0x07
    rd(STRAP, 8'h02, 6, "R5 read stream");
    // R12: reserved write ignored
    wr(STRAP, 8'h80, '{8'h00});
    rd(STRAP, 8'h80, 1, "R12 reserved read");
    // R8 R9: control registers
    wr(STRAP, 8'h02, '{8'h2B, 8'h10, 8'hF0});
    rd(STRAP, 8'h02, 3, "R9 R8 readback");
    pll_locked = 1'b1; sig_detect = 1'b0;
    rd(STRAP, 8'h06, 1, "R11 status");
    // R4: pointer wrap from 0xFF to 0x00
    rd(STRAP, 8'hFF, 2, "R4 pointer wrap");
    // R3: address override
    wr(STRAP, 8'h00, '{{7'h4C, 1'b1}});
    probe_nack(STRAP, "R3 strap ignored under override");
    rd(7'h4C, 8'h00, 1, "R3 override readback");
    // R7: pulse-only reset
    wr(7'h4C, 8'h01, '{8'h01});
    chk(pulses == exp_pulses, "R7 pulse count", pulses, exp_pulses);
    rd(7'h4C, 8'h01, 5, "R7 regs kept, reg1 zero");
    // R6: full restore, transaction continues to 0x02
    wr(7'h4C, 8'h01, '{8'h02, 8'h05});
    rd(7'h4C, 8'h00, 6, "R6 restore readback");
    chk(pulses == exp_pulses, "R6 no pulse", pulses, exp_pulses);
    // R3: clear override, strap active again
    wr(7'h4C, 8'h00, '{8'h00});
    rd(STRAP, 8'h00, 1, "R3 strap restored");
    probe_nack(7'h4C, "R3 programmed addr ignored");

    done = 1'b1;
    cmp_en = 1'b0;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL R1 watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule